// File: doc/BRIEF.md
# Descriptor Ring Producer with Lap Stamping

This block fills a circular ring of fixed-size descriptor entries kept in internal storage. An upstream source hands over a whole entry per valid/ready transfer. The block then writes that entry into the slot at its write index, one 32-bit word per cycle. When all words are in place, the write index moves on by one slot. When the write index passes from the last slot back to slot 0, the lap counter steps.

The final word of every entry carries two stamps: a fixed ring tag and a wrapping 4-bit lap value. A consumer can therefore tell fresh entries from stale ones by looking at the lap value alone, without reading a head pointer. The block does not force the reserved bits of an entry to follow the input; it writes them as zero. The consumer has a combinational read port that reaches any word of any slot. It also has a per-slot vector that compares the lowest lap bit of each slot with the parity the consumer expects on its current pass. The consumer reports its read index back to the block, and the block uses it to hold off the source when the ring is full.

Back-pressure rules: a transfer happens on a rising clock edge where `in_valid` and `in_ready` are both high. The source must hold `in_entry` stable while `in_valid` is high and `in_ready` is low. `in_ready` never depends on `in_valid`.

Top module: `ring_producer`

## Requirements
- R1: `in_ready` is high only when no entry is being written and the ring is not full. After a transfer, `in_ready` stays low for the ENTRY_WORDS (16) cycles that it takes to write the entry.
- R2: The ring is full when the slot after the write index, modulo SLOTS, equals `cons_idx`. At most SLOTS-1 entries are therefore outstanding. While the ring is full, no transfer happens and no slot changes.
- R3: Words 0 to PAYLOAD_WORDS-1 (0 to 8) of an entry are stored exactly as supplied. Word w of the entry is `in_entry[32*w +: 32]`.
- R4: Words PAYLOAD_WORDS to ENTRY_WORDS-2 (9 to 14) and bits [19:0] of word 15 are stored as zero, whatever the input holds in those positions.
- R5: Bits [27:20] of word 15 hold the RING_TAG parameter in every entry that has been written.
- R6: Bits [31:28] of word 15 hold the lap value. Entries written on the first pass after reset carry 1. The value increases by one for each wrap of the write index from slot SLOTS-1 to slot 0.
- R7: The lap value is 4 bits wide. After 15 it wraps to 0, so entries of the sixteenth pass carry 0 and those of the seventeenth pass carry 1.
- R8: Reset clears the write index, the lap counter and every stored word to zero, so that every word reads 0 and the first entry lands in slot 0.
- R9: Word 15 is written last. While words 0 to 14 of an entry are going in, word 15 of that slot still reads its previous value.
- R10: `fresh[k]` is 1 exactly when bit 28 of word 15 of slot k equals `cons_par`.
- R11: `rd_data` is word `rd_word` of slot `rd_slot`, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Source offers an entry |
| in_ready | output | 1 | Block can take an entry |
| in_entry | input | ENTRY_WORDS*32 | Entry words; word w at bits [32w+31:32w] |
| cons_idx | input | $clog2(SLOTS) | Read index returned by the consumer |
| cons_par | input | 1 | Lap parity the consumer expects on its current pass |
| rd_slot | input | $clog2(SLOTS) | Read port slot select |
| rd_word | input | $clog2(ENTRY_WORDS) | Read port word select |
| rd_data | output | 32 | Selected word |
| fresh | output | SLOTS | Per-slot lap parity match |

## Verification
The hardest behaviour to reach from the ports is the lap value wrapping from 15 to 0. Reaching it takes sixteen full passes over the ring, and the consumer index must keep moving all the while so that the ring never blocks. The bench uses a four-slot ring and sets `cons_idx` to the slot about to be written before each transfer. It pushes 68 entries, which carries the lap through 15, 0 and back to 1, and it checks every word of each slot against an arithmetic model. A separate phase fills the ring with `cons_idx` held still. It keeps `in_valid` high against a full ring and confirms that nothing lands.

// File: rtl/ring_prod_pkg.sv
package ring_prod_pkg;
  localparam int WORD_W            = 32;
  localparam int LAP_W             = 4;
  localparam int TAG_W             = 8;
  localparam int LAP_LSB           = 28;
  localparam int TAG_LSB           = 20;
  localparam int DEF_ENTRY_WORDS   = 16;
  localparam int DEF_PAYLOAD_WORDS = 9;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LAP_W-1:0]  lap_t;
  typedef logic [TAG_W-1:0]  tag_t;

  typedef enum logic {WR_IDLE, WR_FILL} wr_state_e;

  // Final word of an entry: lap and tag stamps, everything else zero.
  function automatic word_t stamp_word(lap_t lap, tag_t tag);
    word_t w;
    w = '0;
    w[LAP_LSB +: LAP_W] = lap;
    w[TAG_LSB +: TAG_W] = tag;
    return w;
  endfunction
endpackage

// File: rtl/ring_slot_ptr.sv
module ring_slot_ptr
  import ring_prod_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  logic [SLOT_W-1:0] cons_idx,
  output logic [SLOT_W-1:0] wr_idx,
  output lap_t              pass_q,
  output lap_t              lap_stamp,
  output logic              full
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  logic              at_last;
  logic [SLOT_W-1:0] nxt_idx;

  assign at_last   = (wr_idx == LAST_SLOT);
  assign nxt_idx   = at_last ? '0 : wr_idx + SLOT_W'(1);
  assign full      = (nxt_idx == cons_idx);
  // Entries of pass p (counted from 0 after reset) carry p+1, modulo 16.
  assign lap_stamp = pass_q + lap_t'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx <= '0;
      pass_q <= '0;
    end else if (advance) begin
      wr_idx <= nxt_idx;
      if (at_last) pass_q <= pass_q + lap_t'(1);
    end
  end
endmodule

// File: rtl/ring_entry_writer.sv
module ring_entry_writer
  import ring_prod_pkg::*;
#(
  parameter int   ENTRY_WORDS   = DEF_ENTRY_WORDS,
  parameter int   PAYLOAD_WORDS = DEF_PAYLOAD_WORDS,
  parameter tag_t RING_TAG      = 8'd1,
  parameter int   WRD_W         = $clog2(ENTRY_WORDS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [ENTRY_WORDS*WORD_W-1:0] in_entry,
  input  lap_t                        lap_stamp,
  output logic                        busy,
  output logic                        we,
  output logic [WRD_W-1:0]            wword,
  output word_t                       wdata,
  output logic                        done
);
  localparam int PAY_BITS = PAYLOAD_WORDS * WORD_W;
  localparam logic [WRD_W-1:0] PAY_LAST  = WRD_W'(PAYLOAD_WORDS - 1);
  localparam logic [WRD_W-1:0] WORD_LAST = WRD_W'(ENTRY_WORDS - 1);

  wr_state_e            state_q;
  logic [WRD_W-1:0]     word_q;
  logic [PAY_BITS-1:0]  cap_q;
  word_t                pay_w [PAYLOAD_WORDS];
  logic                 unused_reserved_in;

  // Reserved input words are never captured.
  assign unused_reserved_in = ^in_entry[ENTRY_WORDS*WORD_W-1:PAY_BITS];

  for (genvar g = 0; g < PAYLOAD_WORDS; g++) begin : g_pay
    assign pay_w[g] = cap_q[g*WORD_W +: WORD_W];
  end

  assign busy  = (state_q == WR_FILL);
  assign we    = busy;
  assign wword = word_q;
  assign done  = busy && (word_q == WORD_LAST);

  always_comb begin
    if (word_q <= PAY_LAST)       wdata = pay_w[word_q];
    else if (word_q == WORD_LAST) wdata = stamp_word(lap_stamp, RING_TAG);
    else                          wdata = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WR_IDLE;
      word_q  <= '0;
      cap_q   <= '0;
    end else begin
      case (state_q)
        WR_IDLE: if (start) begin
          cap_q   <= in_entry[PAY_BITS-1:0];
          word_q  <= '0;
          state_q <= WR_FILL;
        end
        WR_FILL: begin
          if (word_q == WORD_LAST) begin
            state_q <= WR_IDLE;
            word_q  <= '0;
          end else begin
            word_q <= word_q + WRD_W'(1);
          end
        end
        default: state_q <= WR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ring_store.sv
module ring_store
  import ring_prod_pkg::*;
#(
  parameter int SLOTS       = 8,
  parameter int ENTRY_WORDS = DEF_ENTRY_WORDS,
  parameter int SLOT_W      = $clog2(SLOTS),
  parameter int WRD_W       = $clog2(ENTRY_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SLOT_W-1:0] wslot,
  input  logic [WRD_W-1:0]  wword,
  input  word_t             wdata,
  input  logic [SLOT_W-1:0] rd_slot,
  input  logic [WRD_W-1:0]  rd_word,
  input  logic              cons_par,
  output word_t             rd_data,
  output logic [SLOTS-1:0]  fresh
);
  word_t mem [SLOTS][ENTRY_WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SLOTS; s++)
        for (int w = 0; w < ENTRY_WORDS; w++)
          mem[s][w] <= '0;
    end else if (we) begin
      mem[wslot][wword] <= wdata;
    end
  end

  assign rd_data = mem[rd_slot][rd_word];

  for (genvar k = 0; k < SLOTS; k++) begin : g_fresh
    assign fresh[k] = ~(mem[k][ENTRY_WORDS-1][LAP_LSB] ^ cons_par);
  end
endmodule

// File: rtl/ring_producer.sv
module ring_producer
  import ring_prod_pkg::*;
#(
  parameter int   SLOTS         = 8,
  parameter int   ENTRY_WORDS   = DEF_ENTRY_WORDS,
  parameter int   PAYLOAD_WORDS = DEF_PAYLOAD_WORDS,
  parameter tag_t RING_TAG      = 8'd1,
  parameter int   SLOT_W        = $clog2(SLOTS),
  parameter int   WRD_W         = $clog2(ENTRY_WORDS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [ENTRY_WORDS*WORD_W-1:0] in_entry,
  input  logic [SLOT_W-1:0]             cons_idx,
  input  logic                          cons_par,
  input  logic [SLOT_W-1:0]             rd_slot,
  input  logic [WRD_W-1:0]              rd_word,
  output logic [WORD_W-1:0]             rd_data,
  output logic [SLOTS-1:0]              fresh
);
  logic              busy, full, accept, wr_done, we;
  logic [SLOT_W-1:0] wr_idx;
  lap_t              pass_q, lap_stamp;
  logic [WRD_W-1:0]  wword;
  word_t             wdata;

  assign in_ready = !busy && !full;
  assign accept   = in_valid && in_ready;

  ring_slot_ptr #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .advance   (wr_done),
    .cons_idx  (cons_idx),
    .wr_idx    (wr_idx),
    .pass_q    (pass_q),
    .lap_stamp (lap_stamp),
    .full      (full)
  );

  ring_entry_writer #(
    .ENTRY_WORDS   (ENTRY_WORDS),
    .PAYLOAD_WORDS (PAYLOAD_WORDS),
    .RING_TAG      (RING_TAG),
    .WRD_W         (WRD_W)
  ) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .in_entry  (in_entry),
    .lap_stamp (lap_stamp),
    .busy      (busy),
    .we        (we),
    .wword     (wword),
    .wdata     (wdata),
    .done      (wr_done)
  );

  ring_store #(
    .SLOTS       (SLOTS),
    .ENTRY_WORDS (ENTRY_WORDS),
    .SLOT_W      (SLOT_W),
    .WRD_W       (WRD_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (we),
    .wslot    (wr_idx),
    .wword    (wword),
    .wdata    (wdata),
    .rd_slot  (rd_slot),
    .rd_word  (rd_word),
    .cons_par (cons_par),
    .rd_data  (rd_data),
    .fresh    (fresh)
  );
endmodule

// File: rtl/ring_producer_chk.sv
module ring_producer_chk
  import ring_prod_pkg::*;
#(
  parameter int   SLOTS         = 8,
  parameter int   ENTRY_WORDS   = DEF_ENTRY_WORDS,
  parameter int   PAYLOAD_WORDS = DEF_PAYLOAD_WORDS,
  parameter tag_t RING_TAG      = 8'd1,
  parameter int   SLOT_W        = $clog2(SLOTS),
  parameter int   WRD_W         = $clog2(ENTRY_WORDS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [SLOT_W-1:0] cons_idx,
  input logic [WRD_W-1:0]  rd_word,
  input logic [WORD_W-1:0] rd_data,
  input logic [SLOT_W-1:0] wr_idx,
  input lap_t              pass_q,
  input logic              done
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);
  localparam logic [WRD_W-1:0]  PAY_LAST  = WRD_W'(PAYLOAD_WORDS - 1);
  localparam logic [WRD_W-1:0]  WORD_LAST = WRD_W'(ENTRY_WORDS - 1);

  logic [SLOT_W-1:0] nxt_slot;
  assign nxt_slot = (wr_idx == LAST_SLOT) ? '0 : wr_idx + SLOT_W'(1);

  // R2: a full ring never offers ready
  p_full_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (nxt_slot == cons_idx) |-> !in_ready);

  // R1: a transfer is followed by a busy cycle
  p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R6: the write index steps by one slot when an entry completes
  p_idx_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (wr_idx == $past(nxt_slot)));

  // R6: index and lap hold between completions
  p_idx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> ($stable(wr_idx) && $stable(pass_q)));

  // R7: the lap counter steps, modulo 16, on a wrap
  p_lap_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && wr_idx == LAST_SLOT) |=> (pass_q == $past(pass_q) + lap_t'(1)));

  // R4: reserved words always read zero
  p_reserved_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_word > PAY_LAST && rd_word < WORD_LAST) |-> (rd_data == '0));

  // R4: low bits of the stamp word always read zero
  p_stamp_low_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_word == WORD_LAST) |-> (rd_data[TAG_LSB-1:0] == '0));

  // R5: a stamp word is either untouched or carries the ring tag
  p_tag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_word == WORD_LAST) |->
      (rd_data == '0 || rd_data[TAG_LSB +: TAG_W] == RING_TAG));
endmodule

bind ring_producer ring_producer_chk #(
  .SLOTS         (SLOTS),
  .ENTRY_WORDS   (ENTRY_WORDS),
  .PAYLOAD_WORDS (PAYLOAD_WORDS),
  .RING_TAG      (RING_TAG),
  .SLOT_W        (SLOT_W),
  .WRD_W         (WRD_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .cons_idx (cons_idx),
  .rd_word  (rd_word),
  .rd_data  (rd_data),
  .wr_idx   (wr_idx),
  .pass_q   (pass_q),
  .done     (wr_done)
);

// File: tb/tb_ring_producer.sv
`timescale 1ns/1ps
module tb_ring_producer;
  localparam int NS   = 4;
  localparam int NW   = 16;
  localparam int NPAY = 9;
  localparam logic [7:0] TAG = 8'h5A;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            in_valid;
  logic            in_ready;
  logic [NW*32-1:0] in_entry;
  logic [1:0]      cons_idx;
  logic            cons_par;
  logic [1:0]      rd_slot;
  logic [3:0]      rd_word;
  logic [31:0]     rd_data;
  logic [NS-1:0]   fresh;

  int total = 0;
  int bad   = 0;
  bit finished = 0;
  logic [31:0] mw15 [NS];

  always #2.5 clk = ~clk;

  ring_producer #(.SLOTS(NS), .ENTRY_WORDS(NW), .PAYLOAD_WORDS(NPAY), .RING_TAG(TAG)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_entry(in_entry), .cons_idx(cons_idx), .cons_par(cons_par),
    .rd_slot(rd_slot), .rd_word(rd_word), .rd_data(rd_data), .fresh(fresh)
  );

  function automatic logic [31:0] pat(int n, int w);
    return {n[7:0], w[7:0], 16'hA55A ^ 16'(n * 7 + w)};
  endfunction

  function automatic logic [3:0] lap_of(int n);
    return 4'((n / NS) + 1);
  endfunction

  function automatic logic [31:0] exp_word(int n, int w);
    if (w < NPAY)    return pat(n, w);
    if (w == NW - 1) return {lap_of(n), TAG, 20'h0};
    return 32'h0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic peek(int s, int w);
    rd_slot = 2'(s);
    rd_word = 4'(w);
    #1;
  endtask

  task automatic wait_ready();
    int g = 0;
    while (!in_ready && g < 1000) begin
      @(negedge clk);
      g++;
    end
    if (!in_ready) check("R1 ready timeout", 32'(in_ready), 32'd1);
  endtask

  task automatic push(int n, bit watch);
    int s = n % NS;
    wait_ready();
    for (int w = 0; w < NW; w++) in_entry[w*32 +: 32] = pat(n, w);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    for (int c = 1; c <= NW; c++) begin
      @(posedge clk);
      @(negedge clk);
      if (c < NW) begin
        check("R1 ready low while writing", 32'(in_ready), 32'd0);
        if (watch) begin
          peek(s, NW - 1);
          check("R9 stamp word unchanged mid-entry", rd_data, mw15[s]);
          peek(s, c - 1);
          check("R11 word visible after its write", rd_data, exp_word(n, c - 1));
        end
      end
    end
    mw15[s] = exp_word(n, NW - 1);
  endtask

  task automatic verify_slot(int n);
    int s = n % NS;
    for (int w = 0; w < NW; w++) begin
      peek(s, w);
      if (w < NPAY)        check("R3 payload word", rd_data, exp_word(n, w));
      else if (w < NW - 1) check("R4 reserved word zero", rd_data, 32'h0);
      else begin
        check("R4 stamp low bits zero", {12'h0, rd_data[19:0]}, 32'h0);
        check("R5 ring tag", {24'h0, rd_data[27:20]}, {24'h0, TAG});
        if (lap_of(n) == 4'd0 || (n / NS) >= 15)
          check("R7 lap wrap value", {28'h0, rd_data[31:28]}, {28'h0, lap_of(n)});
        else
          check("R6 lap value", {28'h0, rd_data[31:28]}, {28'h0, lap_of(n)});
      end
    end
  endtask

  task automatic check_fresh(logic par);
    logic [NS-1:0] e;
    cons_par = par;
    #1;
    for (int k = 0; k < NS; k++) e[k] = (mw15[k][28] == par);
    check("R10 fresh vector", 32'(fresh), 32'(e));
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(150000 * 5);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 act=hung exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NS; k++) mw15[k] = 32'h0;
    rst_n = 1'b0; in_valid = 1'b0; in_entry = '0;
    cons_idx = 2'd0; cons_par = 1'b0; rd_slot = 2'd0; rd_word = 4'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: reset state
    check("R8 ready after reset", 32'(in_ready), 32'd1);
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin
        peek(s, w);
        check("R8 word cleared", rd_data, 32'h0);
      end
    check_fresh(1'b0);
    check_fresh(1'b1);

    // Fill with consumer parked at slot 0; watch ordering on slot 0
    push(0, 1'b1);
    check("R8 first entry in slot 0", 32'(fresh[0]), 32'(1'b1 == cons_par));
    verify_slot(0);
    push(1, 1'b0); verify_slot(1);
    push(2, 1'b0); verify_slot(2);

    // R2: full with three entries outstanding
    check("R2 full after SLOTS-1 entries", 32'(in_ready), 32'd0);
    for (int w = 0; w < NW; w++) in_entry[w*32 +: 32] = 32'hDEAD0000 | 32'(w);
    in_valid = 1'b1;
    repeat (20) @(negedge clk);
    check("R2 still blocked", 32'(in_ready), 32'd0);
    in_valid = 1'b0;
    peek(3, 0);
    check("R2 no write while full", rd_data, 32'h0);
    peek(3, NW - 1);
    check("R2 stamp untouched while full", rd_data, 32'h0);
    cons_idx = 2'd1;
    #1;
    check("R2 ready after consumer moves", 32'(in_ready), 32'd1);

    // Long sweep through lap wrap 15 -> 0 -> 1
    for (int n = 3; n < 68; n++) begin
      @(negedge clk);
      cons_idx = 2'(n % NS);
      push(n, (n % NS) == 0);
      verify_slot(n);
      check_fresh(lap_of(n)[0]);
      check("R10 own slot fresh", 32'(fresh[n % NS]), 32'd1);
      check_fresh(~lap_of(n)[0]);
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule